// File: doc/BRIEF.md
# Strobed Supervisor Watchdog Timer

This block is a supervisor watchdog that counts down on a 32 Hz timebase tick. Its timeout is a 6-bit multiple of the tick period (31.25 ms), so a value of 1 gives 31.25 ms and 63 gives just under 2 s. A value of 0 turns the watchdog off. Software reaches it through one byte-wide control register. The top bit of that register is a restart strobe, the next bit is a write lock, and the low six bits hold the timeout. A separate flag-register read clears the expiry flag.

The lock bit protects the timeout field. A write changes the field only when the lock was already 0 before that write. Every write also stores its own lock bit, so software can keep the watchdog locked and still strobe it without touching the timeout. A new timeout becomes the active one on the first tick after the write and restarts the count from that value. When the count reaches zero without a strobe, the flag is set. The flag raises an interrupt request if the enable input is high. The count then stays at zero until the next strobe.

Top module: `wdg_supervisor`

## Requirements
- R1: After reset the control register reads 8'h40 (strobe 0, lock 1, timeout 0), and both `wdg_flag` and `irq_req` are 0.
- R2: Bits 5:0 of a control write are stored only if the lock bit (bit 6) read 0 before that write. Every write stores its bit 6 as the new lock value.
- R3: Bit 7 (strobe) of the control register always reads 0.
- R4: A stored timeout T becomes active on the first tick after the write and restarts the count at T. With no strobe, the flag rises after the (T+1)-th tick following the write.
- R5: Once timeout T is active, the flag rises exactly on the T-th tick after a restart, and on no earlier tick.
- R6: A write with bit 7 = 1 reloads the count with the active timeout, whatever the lock state. A locked strobe leaves the timeout field unchanged.
- R7: An active timeout of 0 disables the watchdog, and the flag never sets.
- R8: A `flag_rd` pulse clears the flag, but an expiry in the same cycle wins and the flag stays set. After expiry the count holds at zero, so the flag does not set again until a strobe.
- R9: `irq_req` is high exactly when the flag is set and `irq_en` is high.
- R10: A write with bit 7 = 0 does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32hz | input | 1 | One-cycle pulse per 31.25 ms timebase period |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Write data: [7] restart, [6] lock, [5:0] timeout |
| ctl_rdata | output | 8 | Control register readback |
| flag_rd | input | 1 | Pulse when the flag register is read; clears the flag |
| irq_en | input | 1 | Interrupt enable for watchdog expiry |
| wdg_flag | output | 1 | Sticky expiry flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The countdown is driven with several timeouts (0, 2, 3) and several write patterns: unlocked field writes, locked writes with and without the strobe bit, and a field change made while the counter is running. The exact tick count to expiry shows whether the first tick after a write only loads the new value or also counts. Comparing a locked strobe with a locked non-strobe write separates a real restart from a write that merely passes through. A flag read landing on the expiry tick, and extra ticks after expiry, show the set-over-clear priority and that the counter holds at zero.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // Priority between a flag read and an expiry landing in the same cycle
   typedef enum logic {
      PRIO_CLEAR_FIRST = 1'b0,
      PRIO_SET_WINS    = 1'b1
   } flag_prio_e;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs #(
   parameter int   TMO_W    = 6,
   parameter logic LOCK_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [TMO_W+1:0] wdata,
   output logic             lock_q,
   output logic [TMO_W-1:0] tmo_wr_q,
   output logic             strobe_p,
   output logic             tmo_new
);
   localparam int STB_POS = TMO_W + 1;
   localparam int LCK_POS = TMO_W;

   logic field_ok;
   assign field_ok = we && !lock_q;
   assign tmo_new  = field_ok;
   assign strobe_p = we && wdata[STB_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q   <= LOCK_RST;
         tmo_wr_q <= '0;
      end else begin
         if (we)       lock_q   <= wdata[LCK_POS];
         if (field_ok) tmo_wr_q <= wdata[TMO_W-1:0];
      end
   end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
   parameter int TMO_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             strobe,
   input  logic             tmo_new,
   input  logic [TMO_W-1:0] tmo_wr,
   output logic [TMO_W-1:0] cnt_q,
   output logic [TMO_W-1:0] act_q,
   output logic             pend_q,
   output logic             expire
);
   localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

   logic running;
   assign running = (act_q != '0) && (cnt_q != '0);
   assign expire  = tick && !pend_q && !strobe && running && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (tmo_new) begin
         pend_q <= 1'b1;
      end else if (tick) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         cnt_q <= '0;
      end else if (tick && pend_q) begin
         act_q <= tmo_wr;
         cnt_q <= tmo_wr;
      end else if (strobe) begin
         cnt_q <= act_q;
      end else if (tick && running) begin
         cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/wdg_flag.sv
module wdg_flag
   import wdg_pkg::*;
#(
   parameter flag_prio_e PRIO = PRIO_SET_WINS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic rd_clr,
   input  logic irq_en,
   output logic flag_q,
   output logic irq_req
);
   generate
      if (PRIO == PRIO_SET_WINS) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag_q <= 1'b0;
            else if (expire) flag_q <= 1'b1;
            else if (rd_clr) flag_q <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag_q <= 1'b0;
            else if (rd_clr) flag_q <= 1'b0;
            else if (expire) flag_q <= 1'b1;
         end
      end
   endgenerate

   assign irq_req = flag_q && irq_en;
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
   import wdg_pkg::*;
#(
   parameter int         TMO_W    = 6,
   parameter logic       LOCK_RST = 1'b1,
   parameter flag_prio_e PRIO     = PRIO_SET_WINS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_32hz,
   input  logic             ctl_we,
   input  logic [TMO_W+1:0] ctl_wdata,
   output logic [TMO_W+1:0] ctl_rdata,
   input  logic             flag_rd,
   input  logic             irq_en,
   output logic             wdg_flag,
   output logic             irq_req
);
   generate
      if (TMO_W < 1 || TMO_W > 16) begin : g_bad_width
         $error("wdg_supervisor: TMO_W out of range");
      end
   endgenerate

   logic             lock_q;
   logic [TMO_W-1:0] tmo_wr_q;
   logic             strobe_p;
   logic             tmo_new;
   logic [TMO_W-1:0] cnt_q;
   logic [TMO_W-1:0] act_q;
   logic             pend_q;
   logic             expire;

   wdg_regs #(.TMO_W(TMO_W), .LOCK_RST(LOCK_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
      .lock_q(lock_q), .tmo_wr_q(tmo_wr_q), .strobe_p(strobe_p), .tmo_new(tmo_new)
   );

   wdg_count #(.TMO_W(TMO_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick_32hz), .strobe(strobe_p),
      .tmo_new(tmo_new), .tmo_wr(tmo_wr_q),
      .cnt_q(cnt_q), .act_q(act_q), .pend_q(pend_q), .expire(expire)
   );

   wdg_flag #(.PRIO(PRIO)) u_flag (
      .clk(clk), .rst_n(rst_n), .expire(expire), .rd_clr(flag_rd),
      .irq_en(irq_en), .flag_q(wdg_flag), .irq_req(irq_req)
   );

   // Strobe is write-only: it reads back as 0
   assign ctl_rdata = {1'b0, lock_q, tmo_wr_q};
endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk #(
   parameter int TMO_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_32hz,
   input logic             ctl_we,
   input logic [TMO_W+1:0] ctl_wdata,
   input logic [TMO_W+1:0] ctl_rdata,
   input logic             flag_rd,
   input logic             irq_en,
   input logic             wdg_flag,
   input logic             irq_req,
   input logic [TMO_W-1:0] cnt_q,
   input logic [TMO_W-1:0] act_q,
   input logic             pend_q
);
   p_strobe_reads0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[TMO_W+1] == 1'b0);

   p_locked_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_rdata[TMO_W]) |=> $stable(ctl_rdata[TMO_W-1:0]));

   p_rise_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdg_flag) |-> $past(tick_32hz));

   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd && !tick_32hz) |=> !wdg_flag);

   p_zero_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !ctl_we && !pend_q) |=> cnt_q == '0);

   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == '0 && !pend_q) |=> !$rose(wdg_flag));

   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (wdg_flag && irq_en));
endmodule

bind wdg_supervisor wdg_supervisor_chk #(.TMO_W(TMO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_32hz(tick_32hz), .ctl_we(ctl_we),
   .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .flag_rd(flag_rd),
   .irq_en(irq_en), .wdg_flag(wdg_flag), .irq_req(irq_req),
   .cnt_q(cnt_q), .act_q(act_q), .pend_q(pend_q)
);

// File: tb/sim_wdg_supervisor.sv
`timescale 1ns/1ps
module sim_wdg_supervisor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_32hz = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_rdata;
   logic       flag_rd = 1'b0;
   logic       irq_en = 1'b0;
   logic       wdg_flag;
   logic       irq_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wdg_supervisor u0 (
      .clk(clk), .rst_n(rst_n), .tick_32hz(tick_32hz), .ctl_we(ctl_we),
      .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .flag_rd(flag_rd),
      .irq_en(irq_en), .wdg_flag(wdg_flag), .irq_req(irq_req)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ctl_we = 1'b0; tick_32hz = 1'b0; flag_rd = 1'b0; irq_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      ctl_we = 1'b1; ctl_wdata = d;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         tick_32hz = 1'b1;
         @(negedge clk);
         tick_32hz = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic rd_flag();
      flag_rd = 1'b1;
      @(negedge clk);
      flag_rd = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 rdata", ctl_rdata, 8'h40);
      check("R1 flag", wdg_flag, 0);
      check("R1 irq", irq_req, 0);
   endtask

   task automatic t_lock();
      do_reset();
      wr(8'h05);                    // locked: field kept, lock cleared
      check("R2 locked write", ctl_rdata, 8'h00);
      wr(8'h45);                    // unlocked: field written, lock set
      check("R2 unlocked write", ctl_rdata, 8'h45);
      wr(8'h3F);                    // locked again: only lock changes
      check("R2 field kept", ctl_rdata, 8'h05);
      wr(8'hC7);                    // strobe bit set, unlocked write
      check("R3 strobe reads 0", ctl_rdata, 8'h47);
   endtask

   task automatic t_load();
      do_reset();
      wr(8'h00);
      wr(8'h03);
      tick(3);
      check("R4 no flag after T ticks", wdg_flag, 0);
      tick(1);
      check("R4 flag after T+1 ticks", wdg_flag, 1);
   endtask

   task automatic t_strobe();
      do_reset();
      wr(8'h00);
      wr(8'h43);                    // T=3, locked
      tick(3);                      // load + 2 counts
      wr(8'hC0);                    // locked strobe
      check("R6 field unchanged", ctl_rdata, 8'h43);
      tick(2);
      check("R6 restart delays flag", wdg_flag, 0);
      tick(1);
      check("R5 flag on T-th tick", wdg_flag, 1);
      rd_flag();
      wr(8'hC0);
      tick(2);
      wr(8'h40);                    // no strobe bit
      tick(1);
      check("R10 no restart", wdg_flag, 1);
   endtask

   task automatic t_flag();
      do_reset();
      wr(8'h00);
      wr(8'h42);                    // T=2
      tick(3);
      check("R8 expired", wdg_flag, 1);
      rd_flag();
      check("R8 read clears", wdg_flag, 0);
      tick(5);
      check("R8 count holds at zero", wdg_flag, 0);
      wr(8'hC0);
      tick(1);
      tick_32hz = 1'b1; flag_rd = 1'b1;
      @(negedge clk);
      tick_32hz = 1'b0; flag_rd = 1'b0;
      check("R8 set wins over read", wdg_flag, 1);
   endtask

   task automatic t_disable();
      do_reset();
      wr(8'h00);
      wr(8'h40);                    // T=0
      tick(80);
      check("R7 disabled", wdg_flag, 0);
      wr(8'h00);
      wr(8'h02);                    // T=2, unlocked
      tick(2);                      // load + 1 count
      wr(8'h00);                    // change to T=0 while running
      tick(10);
      check("R7 disabled mid-run", wdg_flag, 0);
   endtask

   task automatic t_irq();
      do_reset();
      wr(8'h00);
      wr(8'h41);                    // T=1
      tick(2);
      check("R9 irq masked", irq_req, 0);
      irq_en = 1'b1;
      @(negedge clk);
      check("R9 irq raised", irq_req, 1);
      rd_flag();
      check("R9 irq drops with flag", irq_req, 0);
   endtask

   initial begin
      t_reset();
      t_lock();
      t_load();
      t_strobe();
      t_flag();
      t_disable();
      t_irq();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule